// File: doc/BRIEF.md
# Serial Flash Ready-Status Poller

This block sits on the host side of a single-lane SPI link to a serial NOR flash. Once supply is valid and the system pulses `start`, it keeps reading the flash's flag status register (opcode 0x70). Each read gets its own chip-select frame. The block decides that the device is ready only when the ready bit (bit 7) reads 1 on both reads of a pair. It is used after power-up, and after the system has issued a program or erase by other means.

Until the block has confirmed once that power-up is over, a ready pair is not enough. It must be followed by a status register read (opcode 0x05) that shows both the write-in-progress bit and the write-enable-latch bit clear. This phase starts again after reset and after any loss of the power-good input.

The block never sends any opcode other than these two. A limit on the number of polls ends a run that never succeeds, and raises a sticky timeout flag.

Top module: `flash_ready_poller`

## Requirements
- R1: After reset, `cs_n` is 1, `sck` is 0, `mosi` is 0, and `busy`, `done` and `timeout_err` are all 0.
- R2: While `pwr_ok` is 0, `cs_n` is 1 and `start` is ignored. If `pwr_ok` falls during a run, `cs_n` goes high at once, `busy` is 0 from the next cycle, and the run ends without `done`.
- R3: Each frame uses SPI mode 0 and has exactly 16 `sck` pulses, with `sck` low whenever `cs_n` is high. An 8-bit opcode is driven MSB first on `mosi` and changes after falling edges. Then 8 response bits are sampled MSB first from `miso` on rising edges.
- R4: A poll is two flag-status reads (opcode 0x70), each in its own chip-select frame. The ready bit is bit 7 of the response, and 1 means ready.
- R5: Readiness needs bit 7 = 1 on both reads of the same pair. If either read shows 0, the poll fails and a new pair follows.
- R6: During the power-up phase, a ready pair is followed by one status read (opcode 0x05). The run completes only if bit 0 (write in progress) and bit 1 (write enable latch) are both 0; otherwise the poll fails. Once this succeeds, later runs skip the status read, until reset or a `pwr_ok` loss.
- R7: No opcode other than 0x70 and 0x05 is ever sent.
- R8: Between two frames, `cs_n` stays high for at least `CSH_SCK` SCK periods (2·`CSH_SCK`·`HALF_DIV` clock cycles), where `CSH_SCK` ≥ 2.
- R9: `done` is high for exactly one cycle, and `busy` is high in that cycle. `busy` is high from the cycle after an accepted `start` until that cycle, and low in the cycle after it.
- R10: After `MAX_POLLS` failed polls, `timeout_err` is set, `busy` drops in the same cycle and no `done` is given. `timeout_err` stays set until the next accepted `start` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok | input | 1 | Supply-valid indication |
| start | input | 1 | Begin a readiness run (one-cycle pulse) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse: readiness confirmed |
| timeout_err | output | 1 | Sticky poll-limit error |
| sck | output | 1 | SPI clock, mode 0 |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to the flash |
| miso | input | 1 | SPI data from the flash |

## Verification
The bench acts as the flash. It serves ready-bit patterns in which only the first read is ready, only the second is ready, or both are ready. These separate true pair checking from a check on a single read, or on the first or last read alone. A byte of 0x7F, with every bit set except bit 7, confirms that only bit 7 is taken as the ready bit. Status bytes with the write bits set, and then clear, show whether the extra power-up read gates completion. A run made after that read has succeeded shows whether the read is correctly left out. A power-good drop in mid-run shows whether the power-up phase is re-armed.

// File: rtl/frp_pkg.sv
package frp_pkg;

    localparam logic [7:0] OP_RD_FLAG = 8'h70;
    localparam logic [7:0] OP_RD_STAT = 8'h05;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FLAG_A,
        S_FLAG_B,
        S_STAT,
        S_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        E_IDLE,
        E_SHIFT,
        E_GAP
    } eng_state_t;

    typedef struct packed {
        logic       valid;
        logic [7:0] opcode;
    } frame_req_t;

    function automatic logic flag_ready(input logic [7:0] b);
        return b[7];
    endfunction

    function automatic logic status_clear(input logic [7:0] b);
        return (b[0] == 1'b0) && (b[1] == 1'b0);
    endfunction

endpackage

// File: rtl/frp_spi_frame.sv
module frp_spi_frame
    import frp_pkg::*;
#(
    parameter int HALF_DIV = 4,
    parameter int CSH_SCK  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       abort,
    input  frame_req_t req,
    output logic       frame_done,
    output logic [7:0] rx_byte,
    output logic       sck,
    output logic       cs_n,
    output logic       mosi,
    input  logic       miso
);
    localparam int GAP_CYC = 2 * CSH_SCK * HALF_DIV;
    localparam int DIV_W   = $clog2(HALF_DIV + 1);
    localparam int GAP_W   = $clog2(GAP_CYC + 1);

    eng_state_t       st;
    logic [DIV_W-1:0] div_cnt;
    logic [4:0]       edge_cnt;
    logic [7:0]       txsr;
    logic [7:0]       rxsr;
    logic [GAP_W-1:0] gap_cnt;
    logic             sck_r;
    logic             cs_r;
    logic             done_r;
    logic             tick;

    assign tick = (div_cnt == DIV_W'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            st       <= E_IDLE;
            div_cnt  <= '0;
            edge_cnt <= '0;
            txsr     <= '0;
            rxsr     <= '0;
            gap_cnt  <= '0;
            sck_r    <= 1'b0;
            cs_r     <= 1'b1;
            done_r   <= 1'b0;
        end else begin
            done_r <= 1'b0;
            case (st)
                E_IDLE: begin
                    if (req.valid) begin
                        st       <= E_SHIFT;
                        cs_r     <= 1'b0;
                        txsr     <= req.opcode;
                        div_cnt  <= '0;
                        edge_cnt <= '0;
                    end
                end
                E_SHIFT: begin
                    div_cnt <= tick ? '0 : div_cnt + 1'b1;
                    if (tick) begin
                        edge_cnt <= edge_cnt + 1'b1;
                        if (!edge_cnt[0]) begin
                            sck_r <= 1'b1;
                            if (edge_cnt[4]) rxsr <= {rxsr[6:0], miso};
                        end else begin
                            sck_r <= 1'b0;
                            txsr  <= {txsr[6:0], 1'b0};
                            if (edge_cnt == 5'd31) begin
                                st      <= E_GAP;
                                cs_r    <= 1'b1;
                                gap_cnt <= '0;
                            end
                        end
                    end
                end
                E_GAP: begin
                    gap_cnt <= gap_cnt + 1'b1;
                    if (gap_cnt == GAP_W'(GAP_CYC - 1)) begin
                        st     <= E_IDLE;
                        done_r <= 1'b1;
                    end
                end
                default: st <= E_IDLE;
            endcase
        end
    end

    assign sck        = sck_r;
    assign cs_n       = cs_r;
    assign mosi       = txsr[7];
    assign rx_byte    = rxsr;
    assign frame_done = done_r;

    // Deselect-time monitor for the inter-frame gap check
    logic [GAP_W:0] hi_cnt;
    always_ff @(posedge clk) begin
        if (rst) hi_cnt <= (GAP_W+1)'(GAP_CYC);
        else if (!cs_r) hi_cnt <= '0;
        else if (hi_cnt < (GAP_W+1)'(GAP_CYC)) hi_cnt <= hi_cnt + 1'b1;
    end

    p_sck_low_deselected_r3: assert property (@(posedge clk) disable iff (rst)
        cs_r |-> !sck_r);

    p_cs_gap_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_r) |-> ($past(hi_cnt) >= (GAP_W+1)'(GAP_CYC)));

endmodule

// File: rtl/frp_poll_seq.sv
module frp_poll_seq
    import frp_pkg::*;
#(
    parameter int MAX_POLLS = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_ok,
    input  logic       start,
    input  logic       eng_done,
    input  logic [7:0] eng_rx,
    output frame_req_t req,
    output logic       busy,
    output logic       done,
    output logic       timeout_err
);
    localparam int POLL_W = $clog2(MAX_POLLS + 1);

    seq_state_t        st;
    logic              issue;
    logic              first_rdy;
    logic              pu_ok;
    logic              to_r;
    logic [POLL_W-1:0] poll_cnt;
    logic              pair_ok;
    logic              poll_fail;
    logic              last_poll;

    always_comb begin
        pair_ok   = first_rdy && flag_ready(eng_rx);
        poll_fail = eng_done && (((st == S_FLAG_B) && !pair_ok) ||
                                 ((st == S_STAT) && !status_clear(eng_rx)));
        last_poll = (poll_cnt == POLL_W'(MAX_POLLS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            issue     <= 1'b0;
            first_rdy <= 1'b0;
            pu_ok     <= 1'b0;
            to_r      <= 1'b0;
            poll_cnt  <= '0;
        end else if (!pwr_ok) begin
            st    <= S_IDLE;
            issue <= 1'b0;
            pu_ok <= 1'b0;
        end else begin
            issue <= 1'b0;
            if (poll_fail) begin
                if (last_poll) begin
                    to_r <= 1'b1;
                    st   <= S_IDLE;
                end else begin
                    poll_cnt <= poll_cnt + 1'b1;
                    st       <= S_FLAG_A;
                    issue    <= 1'b1;
                end
            end else begin
                case (st)
                    S_IDLE: begin
                        if (start) begin
                            st       <= S_FLAG_A;
                            issue    <= 1'b1;
                            poll_cnt <= '0;
                            to_r     <= 1'b0;
                        end
                    end
                    S_FLAG_A: begin
                        if (eng_done) begin
                            first_rdy <= flag_ready(eng_rx);
                            st        <= S_FLAG_B;
                            issue     <= 1'b1;
                        end
                    end
                    S_FLAG_B: begin
                        if (eng_done) begin
                            if (pu_ok) begin
                                st <= S_DONE;
                            end else begin
                                st    <= S_STAT;
                                issue <= 1'b1;
                            end
                        end
                    end
                    S_STAT: begin
                        if (eng_done) begin
                            pu_ok <= 1'b1;
                            st    <= S_DONE;
                        end
                    end
                    S_DONE:  st <= S_IDLE;
                    default: st <= S_IDLE;
                endcase
            end
        end
    end

    assign req.valid   = issue;
    assign req.opcode  = (st == S_STAT) ? OP_RD_STAT : OP_RD_FLAG;
    assign busy        = (st != S_IDLE);
    assign done        = (st == S_DONE);
    assign timeout_err = to_r;

    p_opcode_legal_r7: assert property (@(posedge clk) disable iff (rst)
        req.valid |-> (req.opcode == OP_RD_FLAG || req.opcode == OP_RD_STAT));

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && !busy);

    p_done_in_busy_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    p_timeout_idle_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_err) |-> (!busy && !done));

    p_nopwr_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !pwr_ok |=> !busy);

endmodule

// File: rtl/flash_ready_poller.sv
module flash_ready_poller
    import frp_pkg::*;
#(
    parameter int HALF_DIV  = 4,
    parameter int CSH_SCK   = 2,
    parameter int MAX_POLLS = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_ok,
    input  logic start,
    output logic busy,
    output logic done,
    output logic timeout_err,
    output logic sck,
    output logic cs_n,
    output logic mosi,
    input  logic miso
);
    frame_req_t req;
    logic       eng_done;
    logic [7:0] eng_rx;
    logic       eng_sck;
    logic       eng_cs_n;
    logic       eng_mosi;

    frp_poll_seq #(.MAX_POLLS(MAX_POLLS)) i_seq (
        .clk        (clk),
        .rst        (rst),
        .pwr_ok     (pwr_ok),
        .start      (start),
        .eng_done   (eng_done),
        .eng_rx     (eng_rx),
        .req        (req),
        .busy       (busy),
        .done       (done),
        .timeout_err(timeout_err)
    );

    frp_spi_frame #(.HALF_DIV(HALF_DIV), .CSH_SCK(CSH_SCK)) i_eng (
        .clk       (clk),
        .rst       (rst),
        .abort     (!pwr_ok),
        .req       (req),
        .frame_done(eng_done),
        .rx_byte   (eng_rx),
        .sck       (eng_sck),
        .cs_n      (eng_cs_n),
        .mosi      (eng_mosi),
        .miso      (miso)
    );

    // Supply-valid gating keeps the flash deselected with no clock delay
    assign cs_n = eng_cs_n | ~pwr_ok;
    assign sck  = eng_sck & pwr_ok;
    assign mosi = eng_mosi & pwr_ok;

endmodule

// File: tb/test_flash_ready_poller.sv
module test_flash_ready_poller;

    localparam int HALF_DIV  = 2;
    localparam int CSH_SCK   = 3;
    localparam int MAX_POLLS = 6;
    localparam int GAP_MIN   = 2 * CSH_SCK * HALF_DIV;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_ok = 1'b0;
    logic start = 1'b0;
    logic miso = 1'b0;
    logic busy, done, timeout_err, sck, cs_n, mosi;

    always #2 clk = ~clk;

    flash_ready_poller #(.HALF_DIV(HALF_DIV), .CSH_SCK(CSH_SCK), .MAX_POLLS(MAX_POLLS)) i_flash_ready_poller (
        .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .start(start),
        .busy(busy), .done(done), .timeout_err(timeout_err),
        .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Flash model: response queues and behavioural readiness model
    logic [7:0] fsr_q[$];
    logic [7:0] sr_q[$];
    logic [7:0] op_rx;
    logic [7:0] resp;
    int rise_cnt;
    int frames, sr_frames, dones;
    int m_phase, m_polls;
    bit m_first, m_pu_ok, m_expect_done, m_expect_to;

    always @(negedge cs_n) begin
        rise_cnt = 0;
        op_rx = 8'h00;
        resp = 8'hFF;
    end

    always @(posedge sck) begin
        if (!cs_n) begin
            if (rise_cnt < 8) op_rx = {op_rx[6:0], mosi};
            rise_cnt++;
            if (rise_cnt == 8) begin
                if (op_rx == 8'h70) resp = (fsr_q.size() > 0) ? fsr_q.pop_front() : 8'h00;
                else if (op_rx == 8'h05) resp = (sr_q.size() > 0) ? sr_q.pop_front() : 8'hFF;
                else resp = 8'hFF;
            end
        end
    end

    always @(negedge sck) begin
        if (!cs_n && rise_cnt >= 8 && rise_cnt < 16) miso = resp[15 - rise_cnt];
        else miso = 1'b0;
    end

    task automatic model_fail();
        m_polls++;
        if (m_polls == MAX_POLLS) m_expect_to = 1'b1;
        m_phase = 0;
    endtask

    always @(posedge cs_n) begin
        if (pwr_ok) begin
            frames++;
            check(rise_cnt == 16, "R3 sck pulses per frame", rise_cnt, 16);
            check(op_rx == 8'h70 || op_rx == 8'h05, "R7 legal opcode", op_rx, 8'h70);
            if (m_phase == 2) begin
                sr_frames++;
                check(op_rx == 8'h05, "R6 status read opcode", op_rx, 8'h05);
                if (resp[1:0] == 2'b00) begin
                    m_pu_ok = 1'b1;
                    m_expect_done = 1'b1;
                end else model_fail();
            end else begin
                check(op_rx == 8'h70, "R4 flag read opcode", op_rx, 8'h70);
                if (m_phase == 0) begin
                    m_first = resp[7];
                    m_phase = 1;
                end else if (m_first && resp[7]) begin
                    if (m_pu_ok) m_expect_done = 1'b1;
                    else m_phase = 2;
                end else model_fail();
            end
        end
    end

    // Per-clock comparison against the model
    bit prev_done = 1'b0, prev_cs = 1'b1, prev_to = 1'b0, hi_valid = 1'b0;
    int hi_cnt = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!pwr_ok) begin
                m_pu_ok = 1'b0;
                check(cs_n == 1'b1, "R2 deselected without power", cs_n, 1);
            end
            if (cs_n) check(sck == 1'b0, "R3 sck idles low", sck, 0);
            if (done) begin
                dones++;
                check(m_expect_done, "R5 done only after confirmed readiness", done, m_expect_done);
                check(busy == 1'b1, "R9 busy during done", busy, 1);
            end
            if (prev_done) check(!done && !busy, "R9 done single cycle and busy drop", {done, busy}, 0);
            if (timeout_err && !prev_to) check(m_expect_to, "R10 timeout only at poll limit", 1, m_expect_to);
            if (prev_cs && !cs_n && hi_valid) begin
                check(hi_cnt >= GAP_MIN, "R8 chip-select high time", hi_cnt, GAP_MIN);
                hi_valid = 1'b0;
            end
            if (!prev_cs && cs_n) begin
                hi_valid = 1'b1;
                hi_cnt = 0;
            end
            if (cs_n) hi_cnt++;
            if (!busy) hi_valid = 1'b0;
            prev_done = done;
            prev_cs = cs_n;
            prev_to = timeout_err;
        end
    end

    task automatic run_start();
        @(negedge clk);
        start = 1'b1;
        m_phase = 0;
        m_polls = 0;
        m_expect_done = 1'b0;
        m_expect_to = 1'b0;
        frames = 0;
        sr_frames = 0;
        dones = 0;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 30000 && busy; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", wd, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(cs_n == 1'b1, "R1 cs_n after reset", cs_n, 1);
        check(sck == 1'b0, "R1 sck after reset", sck, 0);
        check(mosi == 1'b0, "R1 mosi after reset", mosi, 0);
        check(!busy && !done && !timeout_err, "R1 status after reset", {busy, done, timeout_err}, 0);

        // R2: start ignored while power is not valid
        run_start();
        repeat (100) @(negedge clk);
        check(busy == 1'b0, "R2 start ignored without power", busy, 0);
        check(frames == 0, "R2 no frames without power", frames, 0);

        // R4 R5 R6: power-up phase with mixed pairs, then status gating
        pwr_ok = 1'b1;
        repeat (5) @(negedge clk);
        fsr_q = '{8'h00, 8'h80, 8'h80, 8'h00, 8'h00, 8'h00, 8'h80, 8'h80, 8'h80, 8'h80};
        sr_q  = '{8'h03, 8'h00};
        run_start();
        check(busy == 1'b1, "R9 busy after start", busy, 1);
        wait_idle();
        check(frames == 12, "R5 frame count for mixed pairs", frames, 12);
        check(sr_frames == 2, "R6 status reads in power-up phase", sr_frames, 2);
        check(dones == 1, "R6 completion after clear status", dones, 1);
        check(timeout_err == 1'b0, "R10 no timeout", timeout_err, 0);

        // R6: power-up confirmed, status read skipped
        fsr_q = '{8'h80, 8'h80};
        sr_q  = '{};
        run_start();
        wait_idle();
        check(frames == 2, "R6 one pair after power-up confirmed", frames, 2);
        check(sr_frames == 0, "R6 no status read after confirmation", sr_frames, 0);
        check(dones == 1, "R5 ready pair completes", dones, 1);

        // R10 / R4: bit 7 clear with all other bits set never counts as ready
        fsr_q = {};
        for (int i = 0; i < 2 * MAX_POLLS; i++) fsr_q.push_back(8'h7F);
        run_start();
        wait_idle();
        check(frames == 2 * MAX_POLLS, "R10 frames before timeout", frames, 2 * MAX_POLLS);
        check(timeout_err == 1'b1, "R10 timeout raised", timeout_err, 1);
        check(dones == 0, "R4 bit 7 alone is the ready bit", dones, 0);
        repeat (20) @(negedge clk);
        check(timeout_err == 1'b1, "R10 timeout sticky", timeout_err, 1);

        // R10: next start clears the flag
        fsr_q = '{8'h80, 8'h80};
        run_start();
        check(timeout_err == 1'b0, "R10 timeout cleared by start", timeout_err, 1'b0);
        wait_idle();
        check(dones == 1, "R10 run after timeout completes", dones, 1);

        // R2: power loss mid-run, then power-up phase re-armed
        fsr_q = {};
        for (int i = 0; i < 8; i++) fsr_q.push_back(8'h00);
        run_start();
        repeat (150) @(negedge clk);
        pwr_ok = 1'b0;
        #0;
        check(cs_n == 1'b1, "R2 cs_n high at power loss", cs_n, 1);
        @(negedge clk);
        check(busy == 1'b0, "R2 run abandoned at power loss", busy, 0);
        check(dones == 0, "R2 no done on abandoned run", dones, 0);
        repeat (10) @(negedge clk);
        pwr_ok = 1'b1;
        repeat (5) @(negedge clk);
        fsr_q = '{8'h80, 8'h80};
        sr_q  = '{8'h00};
        run_start();
        wait_idle();
        check(sr_frames == 1, "R6 status read again after power loss", sr_frames, 1);
        check(frames == 3, "R6 frames after power loss", frames, 3);
        check(dones == 1, "R6 completion after power loss", dones, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule